// File: doc/BRIEF.md
# Pipelined Burst SRAM with Back-to-Back Read/Write

This block is a single-port synchronous memory organised as byte lanes. It decodes a small command set on every clock edge and runs each access through a two-stage pipeline. A new access can start with an address supplied from outside. An access can also continue the previous one with an address that the block advances internally, in four-beat bursts.

Write data is delayed by the same two accepted edges as read data. Because the two latencies match, a read may follow a write, or a write may follow a read, on the very next cycle with no idle slot on the data bus. The burst counter walks the low two address bits in one of two orders, chosen by a mode pin:
- wrapping increment;
- XOR with the beat number.

A stall input freezes the whole block for as many cycles as it is held. The read bus carries an enable output, so a three-state pad can be placed outside the block.

Top module: `pipe_sram`

## Requirements
- R1: While `stall` is 1 the clock edge is ignored: no command is taken, no burst step happens, memory is not written, and `rdata` / `rdata_oe` keep their values. Accepted edges are the edges where `stall` is 0.
- R2: On an accepted edge with `burst`=0 and `sel_n`=1 the cycle is idle. At the second accepted edge after it, `rdata_oe` drops to 0.
- R3: On an accepted edge with `burst`=0, `sel_n`=0 and `wr_n`=1, `addr` is taken as a read address. Its word appears on `rdata`, with `rdata_oe`=1, after the second accepted edge that follows.
- R4: On an accepted edge with `burst`=0, `sel_n`=0 and `wr_n`=0, `addr` is taken as a write address. `wdata` and `lane_wr_n` are sampled on the second accepted edge after it, and that word is written then.
- R5: On an accepted edge with `burst`=1, `sel_n` and `wr_n` are ignored and the cycle repeats the kind (read, write or idle) of the previous accepted cycle. A continue after an idle cycle is idle.
- R6: With `lin_order`=1, beat k (k=0..3) of a burst uses low address bits (start + k) mod 4.
- R7: With `lin_order`=0, beat k uses low address bits start XOR k.
- R8: Bit i of `lane_wr_n`, when 0, lets `wdata[8i+7:8i]` into lane i of the addressed word. Lanes whose bit is 1 keep their old contents.
- R9: During reset, and after it until the first read reaches the output, `rdata_oe` is 0 whatever `drive_n` is.
- R10: `rdata_oe` is 1 only while `drive_n` is 0 and the pipeline output slot holds a read.
- R11: Address bits above the low two stay those of the load cycle for the whole burst. The burst wraps within its aligned group of four after the fourth beat.
- R12: Reads and writes may alternate on consecutive accepted edges with no idle cycle. A read issued right after a write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| stall | input | 1 | 1 = ignore this clock edge |
| sel_n | input | 1 | Active-low select, used on load cycles only |
| burst | input | 1 | 1 = continue the burst, 0 = load an external address |
| wr_n | input | 1 | 0 = write, 1 = read, on load cycles |
| lane_wr_n | input | 4 | Active-low write enable for each byte lane, sampled with the write data |
| lin_order | input | 1 | 1 = linear burst order, 0 = XOR order |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| drive_n | input | 1 | Active-low output enable |
| rdata | output | 32 | Read data |
| rdata_oe | output | 1 | Drive enable for the external three-state bus |

## Verification
Every command result lands after the second accepted edge that follows it. Read data and the bus enable show up in that slot, write data is consumed at that edge, and a stalled edge moves none of this forward. The bench keeps its own queue-style reference of the two in-flight slots and advances it only on edges where `stall` was low. It compares `rdata_oe` and `rdata` half a cycle after every edge, so a one-cycle slip in latency, or a stall that leaks into the pipeline, shows up as a mismatch in that very cycle. Burst orders and lane masking are observed through the read data, since every stored word encodes its own address.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/psr_addr_gen.sv
module psr_addr_gen
  import psr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              sel_n,
  input  logic              burst,
  input  logic              wr_n,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr,
  input  op_e               last_op,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    hi_q, hi_d;
  logic [BURST_W-1:0] start_q, start_d;
  logic [BURST_W-1:0] beat_q, beat_d;
  logic [BURST_W-1:0] beat_inc, low_next;

  // next-state: decode the command and form the issued address
  always_comb begin
    hi_d     = hi_q;
    start_d  = start_q;
    beat_d   = beat_q;
    beat_inc = beat_q + 1'b1;
    low_next = lin_order ? (start_q + beat_inc) : (start_q ^ beat_inc);
    if (!burst) begin
      hi_d     = addr[ADDR_W-1:BURST_W];
      start_d  = addr[BURST_W-1:0];
      beat_d   = '0;
      iss_addr = addr;
      if (sel_n)     iss_op = OP_IDLE;
      else if (wr_n) iss_op = OP_RD;
      else           iss_op = OP_WR;
    end else begin
      iss_op   = last_op;
      iss_addr = {hi_q, low_next};
      if (last_op != OP_IDLE) beat_d = beat_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (cke) begin
      hi_q    <= hi_d;
      start_q <= start_d;
      beat_q  <= beat_d;
    end
  end

  // checker shadow of the previously issued address and order mode
  logic [ADDR_W-1:0] prv_addr_q;
  logic              prv_lin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_addr_q <= '0;
      prv_lin_q  <= 1'b0;
    end else if (cke) begin
      prv_addr_q <= iss_addr;
      prv_lin_q  <= lin_order;
    end
  end

  assert_lin_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && burst && last_op != OP_IDLE && lin_order && prv_lin_q)
      |-> iss_addr[1:0] == prv_addr_q[1:0] + 2'd1);

  assert_xor_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && burst && last_op != OP_IDLE && !lin_order && !prv_lin_q)
      |-> iss_addr[0] != prv_addr_q[0]);

  assert_hi_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && burst && last_op != OP_IDLE)
      |-> iss_addr[ADDR_W-1:BURST_W] == prv_addr_q[ADDR_W-1:BURST_W]);
endmodule

// File: rtl/psr_pipe.sv
module psr_pipe
  import psr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  op_e               iss_op,
  input  logic [ADDR_W-1:0] iss_addr,
  output op_e               s1_op,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr
);
  logic [ADDR_W-1:0] s1_addr;
  op_e               s1_op_d, s2_op_d;
  logic [ADDR_W-1:0] s1_addr_d, s2_addr_d;

  always_comb begin
    s1_op_d   = s1_op;
    s1_addr_d = s1_addr;
    s2_op_d   = s2_op;
    s2_addr_d = s2_addr;
    if (cke) begin
      s1_op_d   = iss_op;
      s1_addr_d = iss_addr;
      s2_op_d   = s1_op;
      s2_addr_d = s1_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
    end else begin
      s1_op   <= s1_op_d;
      s1_addr <= s1_addr_d;
      s2_op   <= s2_op_d;
      s2_addr <= s2_addr_d;
    end
  end
endmodule

// File: rtl/psr_store.sv
module psr_store
  import psr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_wr_n,
  output logic [LANES*LANE_W-1:0] rdata_q,
  output logic                    rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] lane_rd;
  logic                         do_wr, do_rd;

  assign do_wr = cke && (s2_op == OP_WR);
  assign do_rd = cke && (s2_op == OP_RD);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (do_wr && !lane_wr_n[l]) begin
        bank[s2_addr] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    assign lane_rd[l] = bank[s2_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rd_q    <= 1'b0;
    end else if (cke) begin
      rd_q <= (s2_op == OP_RD);
      if (do_rd) rdata_q <= lane_rd;
    end
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import psr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    sel_n,
  input  logic                    burst,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    lin_order,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    drive_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic              cke;
  op_e               iss_op, s1_op, s2_op;
  logic [ADDR_W-1:0] iss_addr, s2_addr;
  logic              rd_q;

  assign cke = !stall;

  psr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cke       (cke),
    .sel_n     (sel_n),
    .burst     (burst),
    .wr_n      (wr_n),
    .lin_order (lin_order),
    .addr      (addr),
    .last_op   (s1_op),
    .iss_op    (iss_op),
    .iss_addr  (iss_addr)
  );

  psr_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .cke      (cke),
    .iss_op   (iss_op),
    .iss_addr (iss_addr),
    .s1_op    (s1_op),
    .s2_op    (s2_op),
    .s2_addr  (s2_addr)
  );

  psr_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cke       (cke),
    .s2_op     (s2_op),
    .s2_addr   (s2_addr),
    .wdata     (wdata),
    .lane_wr_n (lane_wr_n),
    .rdata_q   (rdata),
    .rd_q      (rd_q)
  );

  assign rdata_oe = rd_q && !drive_n;

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    stall |=> $stable(rdata));
endmodule

// File: tb/pipe_sram_test.sv
`timescale 1ns/1ps
module pipe_sram_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall, sel_n, burst, wr_n, lin_order, drive_n;
  logic [3:0]  lane_wr_n;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rdata_oe;

  always #2 clk = ~clk;

  pipe_sram uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel_n(sel_n), .burst(burst),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .lin_order(lin_order), .addr(addr),
    .wdata(wdata), .drive_n(drive_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state: ops 0 idle, 1 read, 2 write
  int m_hi, m_start, m_k, m_last;
  int p1_op, p1_addr, p2_op, p2_addr;
  bit exp_rd, exp_known;
  logic [31:0] exp_data;
  logic [31:0] mm [int];

  logic [3:0] g_bw = 4'b0000;
  bit         g_lin = 1'b1;
  bit         g_oe_n = 1'b0;
  logic [7:0] g_salt = 8'h11;

  function automatic logic [31:0] pat(int a, logic [7:0] s);
    logic [7:0] ab = a[7:0];
    return {ab, ~ab, s, ab ^ s};
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rdata_oe actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_word(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hi = 0; m_start = 0; m_k = 0; m_last = 0;
    p1_op = 0; p1_addr = 0; p2_op = 0; p2_addr = 0;
    exp_rd = 0; exp_known = 0; exp_data = '0;
  endtask

  // one clock: drive at negedge, model after posedge, compare at next negedge
  task automatic step(string tag, bit st, bit sn, bit bu, bit wn, int a);
    int op, ia, low;
    logic [31:0] w;
    stall = st; sel_n = sn; burst = bu; wr_n = wn; addr = a[7:0];
    lane_wr_n = g_bw; lin_order = g_lin; drive_n = g_oe_n;
    if (st)              w = 32'hDEAD_BEEF;
    else if (p2_op == 2) w = pat(p2_addr, g_salt);
    else                 w = 32'h0BAD_F00D;
    wdata = w;
    @(posedge clk);
    if (!st) begin
      if (!bu) begin
        op = sn ? 0 : (wn ? 1 : 2);
        ia = a & 255;
        m_hi = ia >> 2; m_start = ia & 3; m_k = 0;
      end else begin
        op = m_last;
        if (op != 0) m_k = (m_k + 1) % 4;
        low = g_lin ? ((m_start + m_k) % 4) : (m_start ^ m_k);
        ia = m_hi * 4 + low;
      end
      if (p2_op == 2) begin
        logic [31:0] old = mm.exists(p2_addr) ? mm[p2_addr] : 32'h0;
        for (int l = 0; l < 4; l++)
          if (!g_bw[l]) old[l*8 +: 8] = w[l*8 +: 8];
        mm[p2_addr] = old;
      end
      exp_rd = (p2_op == 1);
      if (exp_rd) begin
        exp_known = mm.exists(p2_addr);
        exp_data  = exp_known ? mm[p2_addr] : 32'h0;
      end
      p2_op = p1_op; p2_addr = p1_addr;
      p1_op = op;    p1_addr = ia;
      m_last = op;
    end
    @(negedge clk);
    check_bit(tag, rdata_oe, exp_rd && !g_oe_n);
    if (exp_rd && exp_known) check_word(tag, rdata, exp_data);
  endtask

  task automatic ld_rd(string tag, int a); step(tag, 0, 0, 0, 1, a); endtask
  task automatic ld_wr(string tag, int a); step(tag, 0, 0, 0, 0, a); endtask
  task automatic cont(string tag);         step(tag, 0, 1, 1, 0, 8'hA5); endtask
  task automatic idle(string tag);         step(tag, 0, 1, 0, 1, 0); endtask
  task automatic hold(string tag);         step(tag, 1, 0, 0, 0, 8'h5A); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired before the run ended");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 0; sel_n = 1; burst = 0; wr_n = 1;
    lane_wr_n = 4'h0; lin_order = 1; addr = '0; wdata = '0; drive_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check_bit("R9 in reset", rdata_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R9 after reset", rdata_oe, 1'b0);

    // R4: fill words 0..23 with full-width write bursts
    g_lin = 1; g_bw = 4'b0000; g_salt = 8'h11;
    for (int b = 0; b < 6; b++) begin
      ld_wr("R4 write load", b * 4);
      cont("R4 write burst"); cont("R4 write burst"); cont("R4 write burst");
    end
    idle("R2 flush"); idle("R2 flush");

    // R3 and R2: single read then idle slot goes quiet
    ld_rd("R3 read load", 5);
    idle("R2 idle after read"); idle("R2 idle after read"); idle("R2 idle after read");

    // R6: linear burst from 9 -> 9,10,11,8
    g_lin = 1;
    ld_rd("R6 linear", 9); cont("R6 linear"); cont("R6 linear"); cont("R6 linear");
    idle("R6 flush"); idle("R6 flush");

    // R7: XOR order from 6 -> 6,7,4,5 and from 15 -> 15,14,13,12
    g_lin = 0;
    ld_rd("R7 xor", 6); cont("R7 xor"); cont("R7 xor"); cont("R7 xor");
    ld_rd("R7 xor", 15); cont("R7 xor"); cont("R7 xor"); cont("R7 xor");
    idle("R7 flush"); idle("R7 flush");

    // R11: linear burst of six beats from 14 wraps within 12..15
    g_lin = 1;
    ld_rd("R11 wrap", 14);
    for (int i = 0; i < 5; i++) cont("R11 wrap");
    g_lin = 0;
    ld_rd("R11 wrap xor", 17);
    for (int i = 0; i < 5; i++) cont("R11 wrap xor");
    idle("R11 flush"); idle("R11 flush");

    // R12: alternate reads and writes with no gaps
    g_lin = 1; g_salt = 8'h5C;
    ld_rd("R12 alternate", 3);
    ld_wr("R12 alternate", 5);
    ld_rd("R12 alternate", 5);
    ld_wr("R12 alternate", 3);
    ld_rd("R12 alternate", 3);
    ld_wr("R12 alternate", 7);
    ld_rd("R12 alternate", 7);
    idle("R12 flush"); idle("R12 flush");

    // R5: continue inherits write, then read; continue after idle is idle
    g_salt = 8'h77;
    ld_wr("R5 write cont", 20); cont("R5 write cont"); cont("R5 write cont"); cont("R5 write cont");
    ld_rd("R5 read cont", 20); cont("R5 read cont"); cont("R5 read cont"); cont("R5 read cont");
    idle("R5 idle"); cont("R5 cont after idle"); cont("R5 cont after idle");
    cont("R5 cont after idle"); cont("R5 cont after idle");

    // R1: stalls inside a read burst and between write address and data
    ld_rd("R1 stall read", 12); hold("R1 stall"); cont("R1 stall read");
    hold("R1 stall"); hold("R1 stall"); cont("R1 stall read");
    hold("R1 stall"); cont("R1 stall read"); idle("R1 flush"); hold("R1 stall"); idle("R1 flush");
    g_salt = 8'h99;
    ld_wr("R1 stall write", 21); hold("R1 stall"); hold("R1 stall"); idle("R1 write data");
    hold("R1 stall"); idle("R1 flush");
    ld_rd("R1 read back", 21); idle("R1 flush"); idle("R1 flush");

    // R8: lane mask 1010 writes lanes 0 and 2 only
    g_salt = 8'hE3; g_bw = 4'b1010;
    ld_wr("R8 lane mask", 2); idle("R8 lane mask"); idle("R8 lane mask");
    g_bw = 4'b0110;
    ld_wr("R8 lane mask", 10); idle("R8 lane mask"); idle("R8 lane mask");
    g_bw = 4'b0000;
    ld_rd("R8 read back", 2); ld_rd("R8 read back", 10);
    idle("R8 flush"); idle("R8 flush");

    // R10: output enable gates the bus, data still present afterwards
    ld_rd("R10 oe high", 1); cont("R10 oe high");
    g_oe_n = 1; cont("R10 oe high"); cont("R10 oe high");
    g_oe_n = 0; idle("R10 oe low"); idle("R10 oe low");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule